// File: doc/BRIEF.md
# Management-Mode Context Save and Restore Sequencer

This controller sits next to a 32-bit processor core. When the core takes a management interrupt, the sequencer writes the architectural register set into a save area in memory, one word at a time. It then drives the fixed register values that the new mode starts with onto a restore bus. When the core executes the resume instruction, the sequencer reads the save area back and presents each word on the restore bus with a one-hot register select. At the end of the resume it clears the mode flags.

The sequencer holds the mode flag, the NMI-block flag, the "entered while NMIs were blocked" flag and the relocatable area base. All save-area addresses are computed from that base. Memory traffic uses a valid/ready master port. A request stays on the port, with address, direction and write data unchanged, until the memory raises `mem_ready`. Read data is taken in the same cycle as `mem_ready`. The memory may hold `mem_ready` low for any number of cycles, and the sequence simply waits. The snapshot bus must be held stable by the core while `busy` is high.

Top module: `mgmt_ctx_seq`

## Requirements
- R1: On entry, each of the 39 context words is written to base + 0x8000 + its slot. Slots: index 0 CR0 0x7FFC, 1 CR3 0x7FF8, 2 flags 0x7FF4, 3 IP 0x7FF0. Indices 4..11 (EDI, ESI, EBP, ESP, EBX, EDX, ECX, EAX) take 0x7FEC down to 0x7FD0 in steps of 4. Index 12 DR6 0x7FCC, 13 DR7 0x7FC8, 14 CR4 0x7F14. For segment s = 0..5, index 15+4s is the selector at 0x7FA8+4s. Let o = 0x7F84+12s for s<3 and 0x7F2C+12(s-3) otherwise. Index 16+4s is the base at o+8, 17+4s the limit at o+4 and 18+4s the attribute at o. An attribute is stored as (value >> 8) & 0xF0FF.
- R2: On entry, the sequencer also writes the revision word 0x00020000 at slot 0x7EFC and the current base at slot 0x7EF8, for 41 writes in total.
- R3: Accepting an entry sets `in_mode` in the same edge as `busy` rises. If `nmi_blk` was already set, it sets `nmi_nest`; otherwise it sets `nmi_blk`.
- R4: After the writes, the sequencer emits 22 entry strobes in this order. CR0 gets its captured value with bits 0, 2, 3 and 31 cleared. IP gets 0x8000, DR7 gets 0x400 and CR4 gets 0.
- R5: The entry strobes continue, for each segment s = 0..5, with the selector, the base and then the limit. For segment 1 (code), the selector is base[19:4] and the base is the area base. For every other segment, the selector and base are 0. Every limit is 0xFFFFFFFF.
- R6: On resume, the sequencer reads the 39 slots in index order. Each word appears one cycle after its read completes, with `ld_we` high and exactly bit `index` of `ld_sel` set. An attribute word is presented as (word & 0xF0FF) << 8.
- R7: After the register reads, the sequencer reads the revision word. It reads slot 0x7EF8 into the base only when bit 17 of the revision word is set. The base changes at no other time.
- R8: At the end of a resume, `nmi_blk` is cleared only if `nmi_nest` is clear. Then `nmi_nest` and `in_mode` are both cleared. While `nmi_nest` is set, `nmi_block_clr` has no effect.
- R9: A memory request holds its address, direction and write data until `mem_ready` is high. The sequencer issues at most one access per cycle.
- R10: `busy` is high from the cycle after an accepted trigger up to and including the cycle of the single-cycle `done` pulse. The last strobe of each sequence appears no later than `done`.
- R11: A trigger is ignored while `busy` is high. `enter_req` is ignored while in mode, and `resume_req` is ignored outside it.
- R12: After reset, `busy`, `done`, `ld_we`, `in_mode`, `nmi_blk` and `nmi_nest` are 0, and `mm_base` equals `BASE_RESET`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | Management interrupt taken (pulse) |
| resume_req | input | 1 | Resume instruction executed (pulse) |
| nmi_block_set | input | 1 | Core sets NMI blocking |
| nmi_block_clr | input | 1 | Core clears NMI blocking |
| snap_regs | input | 39*32 | Parallel snapshot of the context, word i at bits [32i+31:32i] |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request (read data valid) |
| mem_rdata | input | 32 | Read data |
| ld_we | output | 1 | Restore strobe |
| ld_sel | output | 39 | One-hot register select |
| ld_data | output | 32 | Restored value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | End-of-sequence pulse |
| in_mode | output | 1 | Management mode active |
| nmi_blk | output | 1 | NMI blocking |
| nmi_nest | output | 1 | Mode was entered with NMIs already blocked |
| mm_base | output | 32 | Save-area base register |

## Verification
A wrong sequencer count or a bad slot computation shows up as a save word at the wrong address, or as a restore strobe with the wrong select. The bench sees this within the one sequence in which it happens, because it compares every slot and every strobe. A wrong flag update shows at the flag pins in the cycle after `done`. A wrong decision on the revision word shows as a read count of 40 instead of 41, or the reverse, and as a stale or moved `mm_base` right after `done`. The bench also reloads the save area after moving the base, so a wrong base also shows as out-of-area addresses in the next entry.

// File: rtl/mgmt_ctx_pkg.sv
package mgmt_ctx_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NSEG   = 6;
  localparam int unsigned CORE_N = 15;
  localparam int unsigned NREG   = CORE_N + 4 * NSEG;
  localparam int unsigned NENTRY = 4 + 3 * NSEG;
  localparam int unsigned IDX_W  = $clog2(NREG + 2);

  localparam int unsigned IX_CR0 = 0;
  localparam int unsigned IX_IP  = 3;
  localparam int unsigned IX_DR7 = 13;
  localparam int unsigned IX_CR4 = 14;
  localparam int unsigned SEG_CODE  = 1;
  localparam int unsigned RELOC_BIT = 17;

  localparam logic [WORD_W-1:0] AREA_OFS  = 32'h0000_8000;
  localparam logic [WORD_W-1:0] REV_SLOT  = 32'h0000_7EFC;
  localparam logic [WORD_W-1:0] BASE_SLOT = 32'h0000_7EF8;
  localparam logic [WORD_W-1:0] REV_ID    = 32'h0002_0000;
  localparam logic [WORD_W-1:0] IP_ENTRY  = 32'h0000_8000;
  localparam logic [WORD_W-1:0] DR7_ENTRY = 32'h0000_0400;
  localparam logic [WORD_W-1:0] CR0_CLR   = 32'h8000_000D;
  localparam logic [WORD_W-1:0] ATTR_MASK = 32'h0000_F0FF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SAVE, ST_LOAD, ST_RDREG, ST_RDREV, ST_RDBASE, ST_FIN
  } seq_st_e;

  // save-area slot of context word idx (idx < NREG)
  function automatic logic [WORD_W-1:0] slot_of(input int unsigned idx);
    int unsigned s, f;
    logic [WORD_W-1:0] row;
    if (idx < IX_CR4) return 32'h7FFC - 4 * idx;
    if (idx == IX_CR4) return 32'h7F14;
    s = (idx - CORE_N) / 4;
    f = (idx - CORE_N) % 4;
    row = (s < 3) ? 32'h7F84 + 12 * s : 32'h7F2C + 12 * (s - 3);
    case (f)
      0:       return 32'h7FA8 + 4 * s;
      1:       return row + 8;
      2:       return row + 4;
      default: return row;
    endcase
  endfunction

  function automatic logic is_attr(input int unsigned idx);
    return (idx >= CORE_N) && (idx < NREG) && (((idx - CORE_N) % 4) == 3);
  endfunction

  // register index loaded by entry step j
  function automatic int unsigned entry_reg(input int unsigned j);
    case (j)
      0:       return IX_CR0;
      1:       return IX_IP;
      2:       return IX_DR7;
      3:       return IX_CR4;
      default: return CORE_N + 4 * ((j - 4) / 3) + ((j - 4) % 3);
    endcase
  endfunction
endpackage

// File: rtl/mgmt_ctx_fmt.sv
module mgmt_ctx_fmt
  import mgmt_ctx_pkg::*;
(
  input  logic [IDX_W-1:0]       cnt,
  input  logic                   load_ph,
  input  logic [NREG*WORD_W-1:0] snap,
  input  logic [WORD_W-1:0]      rdata,
  input  logic [WORD_W-1:0]      base,
  input  logic [WORD_W-1:0]      cr0_cap,
  output logic [WORD_W-1:0]      slot,
  output logic [WORD_W-1:0]      sv_word,
  output logic [WORD_W-1:0]      rs_word,
  output logic [WORD_W-1:0]      ent_word,
  output logic [NREG-1:0]        sel_oh
);
  int unsigned k, kc, s, f, sel_src;
  logic [WORD_W-1:0] snap_w;

  always_comb begin
    k  = 32'(cnt);
    kc = (k < NREG) ? k : 0;
    snap_w = snap[kc*WORD_W +: WORD_W];
    s = 0;
    f = 0;

    if (k < NREG)       slot = slot_of(k);
    else if (k == NREG) slot = REV_SLOT;
    else                slot = BASE_SLOT;

    if (k < NREG)       sv_word = is_attr(k) ? ((snap_w >> 8) & ATTR_MASK) : snap_w;
    else if (k == NREG) sv_word = REV_ID;
    else                sv_word = base;

    rs_word = is_attr(k) ? ((rdata & ATTR_MASK) << 8) : rdata;

    case (k)
      0: ent_word = cr0_cap & ~CR0_CLR;
      1: ent_word = IP_ENTRY;
      2: ent_word = DR7_ENTRY;
      3: ent_word = '0;
      default: begin
        s = (k - 4) / 3;
        f = (k - 4) % 3;
        case (f)
          0:       ent_word = (s == SEG_CODE) ? {16'h0, base[19:4]} : '0;
          1:       ent_word = (s == SEG_CODE) ? base : '0;
          default: ent_word = '1;
        endcase
      end
    endcase

    sel_src = load_ph ? entry_reg(k) : k;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign sel_oh[g] = (sel_src == 32'(g));
  end
endmodule

// File: rtl/mgmt_ctx_state.sv
module mgmt_ctx_state
  import mgmt_ctx_pkg::*;
#(
  parameter logic [WORD_W-1:0] BASE_RESET = 32'h0003_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ent,
  input  logic              fin_res,
  input  logic              nmi_set,
  input  logic              nmi_clr,
  input  logic              base_we,
  input  logic [WORD_W-1:0] base_wd,
  output logic              in_mode,
  output logic              nmi_blk,
  output logic              nmi_nest,
  output logic [WORD_W-1:0] base
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_mode  <= 1'b0;
      nmi_blk  <= 1'b0;
      nmi_nest <= 1'b0;
      base     <= BASE_RESET;
    end else begin
      if (start_ent) begin
        in_mode <= 1'b1;
        if (nmi_blk) nmi_nest <= 1'b1;
        else         nmi_blk  <= 1'b1;
      end else if (fin_res) begin
        in_mode  <= 1'b0;
        nmi_nest <= 1'b0;
        if (!nmi_nest) nmi_blk <= 1'b0;
      end else if (nmi_set) begin
        nmi_blk <= 1'b1;
      end else if (nmi_clr && !nmi_nest) begin
        nmi_blk <= 1'b0;
      end
      if (base_we) base <= base_wd;
    end
  end
endmodule

// File: rtl/mgmt_ctx_fsm.sv
module mgmt_ctx_fsm
  import mgmt_ctx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter_req,
  input  logic             resume_req,
  input  logic             in_mode,
  input  logic             mem_ready,
  input  logic             reloc,
  output seq_st_e          st,
  output logic [IDX_W-1:0] cnt,
  output logic             busy,
  output logic             done,
  output logic             start_ent,
  output logic             fin_res,
  output logic             mem_valid,
  output logic             mem_write,
  output logic             ld_fire,
  output logic             base_we
);
  localparam logic [IDX_W-1:0] LAST_SAVE = IDX_W'(NREG + 1);
  localparam logic [IDX_W-1:0] LAST_REG  = IDX_W'(NREG - 1);
  localparam logic [IDX_W-1:0] LAST_ENT  = IDX_W'(NENTRY - 1);
  localparam logic [IDX_W-1:0] IX_REV    = IDX_W'(NREG);
  localparam logic [IDX_W-1:0] IX_BASE   = IDX_W'(NREG + 1);

  logic op_res, hs, start_res;

  always_comb begin
    busy      = (st != ST_IDLE);
    done      = (st == ST_FIN);
    mem_valid = (st == ST_SAVE) || (st == ST_RDREG) || (st == ST_RDREV) || (st == ST_RDBASE);
    mem_write = (st == ST_SAVE);
    hs        = mem_valid && mem_ready;
    start_ent = (st == ST_IDLE) && enter_req && !in_mode;
    start_res = (st == ST_IDLE) && resume_req && in_mode;
    fin_res   = done && op_res;
    ld_fire   = (st == ST_LOAD) || ((st == ST_RDREG) && hs);
    base_we   = (st == ST_RDBASE) && hs;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      op_res <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_ent) begin
            st <= ST_SAVE; cnt <= '0; op_res <= 1'b0;
          end else if (start_res) begin
            st <= ST_RDREG; cnt <= '0; op_res <= 1'b1;
          end
        end
        ST_SAVE: if (hs) begin
          if (cnt == LAST_SAVE) begin st <= ST_LOAD; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        ST_LOAD: begin
          if (cnt == LAST_ENT) begin st <= ST_FIN; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        ST_RDREG: if (hs) begin
          if (cnt == LAST_REG) begin st <= ST_RDREV; cnt <= IX_REV; end
          else cnt <= cnt + 1'b1;
        end
        ST_RDREV: if (hs) begin
          if (reloc) begin st <= ST_RDBASE; cnt <= IX_BASE; end
          else st <= ST_FIN;
        end
        ST_RDBASE: if (hs) st <= ST_FIN;
        default: begin st <= ST_IDLE; cnt <= '0; end
      endcase
    end
  end
endmodule

// File: rtl/mgmt_ctx_seq.sv
module mgmt_ctx_seq
  import mgmt_ctx_pkg::*;
#(
  parameter logic [31:0] BASE_RESET = 32'h0003_0000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enter_req,
  input  logic                   resume_req,
  input  logic                   nmi_block_set,
  input  logic                   nmi_block_clr,
  input  logic [NREG*WORD_W-1:0] snap_regs,
  output logic                   mem_valid,
  output logic                   mem_write,
  output logic [WORD_W-1:0]      mem_addr,
  output logic [WORD_W-1:0]      mem_wdata,
  input  logic                   mem_ready,
  input  logic [WORD_W-1:0]      mem_rdata,
  output logic                   ld_we,
  output logic [NREG-1:0]        ld_sel,
  output logic [WORD_W-1:0]      ld_data,
  output logic                   busy,
  output logic                   done,
  output logic                   in_mode,
  output logic                   nmi_blk,
  output logic                   nmi_nest,
  output logic [WORD_W-1:0]      mm_base
);
  seq_st_e           st;
  logic [IDX_W-1:0]  cnt;
  logic              start_ent, fin_res, ld_fire, base_we;
  logic [WORD_W-1:0] cr0_cap, slot, sv_word, rs_word, ent_word;
  logic [NREG-1:0]   sel_oh;
  logic              load_ph;

  assign load_ph = (st == ST_LOAD);

  mgmt_ctx_fsm u_fsm (
    .clk, .rst_n, .enter_req, .resume_req, .in_mode, .mem_ready,
    .reloc(mem_rdata[RELOC_BIT]),
    .st, .cnt, .busy, .done, .start_ent, .fin_res,
    .mem_valid, .mem_write, .ld_fire, .base_we
  );

  mgmt_ctx_state #(.BASE_RESET(BASE_RESET)) u_state (
    .clk, .rst_n, .start_ent, .fin_res,
    .nmi_set(nmi_block_set), .nmi_clr(nmi_block_clr),
    .base_we, .base_wd(mem_rdata),
    .in_mode, .nmi_blk, .nmi_nest, .base(mm_base)
  );

  mgmt_ctx_fmt u_fmt (
    .cnt, .load_ph, .snap(snap_regs), .rdata(mem_rdata), .base(mm_base),
    .cr0_cap, .slot, .sv_word, .rs_word, .ent_word, .sel_oh
  );

  assign mem_addr  = mm_base + AREA_OFS + slot;
  assign mem_wdata = mem_write ? sv_word : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr0_cap <= '0;
      ld_we   <= 1'b0;
      ld_sel  <= '0;
      ld_data <= '0;
    end else begin
      if (start_ent) cr0_cap <= snap_regs[IX_CR0*WORD_W +: WORD_W];
      ld_we   <= ld_fire;
      ld_sel  <= ld_fire ? sel_oh : '0;
      ld_data <= ld_fire ? (load_ph ? ent_word : rs_word) : '0;
    end
  end
endmodule

// File: rtl/mgmt_ctx_chk.sv
module mgmt_ctx_chk
  import mgmt_ctx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [WORD_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              busy,
  input logic              done,
  input logic              ld_we,
  input logic [NREG-1:0]   ld_sel,
  input logic              in_mode,
  input logic              nmi_blk,
  input logic              nmi_nest,
  input logic [WORD_W-1:0] mm_base
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)); // R9
  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |-> busy); // R10
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |-> $countones(ld_sel) == 1); // R6
  AST_MODE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_mode) |-> busy); // R3
  AST_MODE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_mode) |-> $past(done)); // R8
  AST_NEST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_nest |-> in_mode && nmi_blk); // R8
  AST_BASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(mm_base)); // R7
endmodule

bind mgmt_ctx_seq mgmt_ctx_chk u_chk (
  .clk, .rst_n, .mem_valid, .mem_ready, .mem_write, .mem_addr, .mem_wdata,
  .busy, .done, .ld_we, .ld_sel, .in_mode, .nmi_blk, .nmi_nest, .mm_base
);

// File: tb/tb_mgmt_ctx_seq.sv
module tb_mgmt_ctx_seq;
  localparam int NR = 39;
  localparam int NE = 22;
  localparam logic [31:0] B0 = 32'h0003_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enter_req = 0, resume_req = 0, nmi_block_set = 0, nmi_block_clr = 0;
  logic [NR*32-1:0] snap_regs = '0;
  logic mem_valid, mem_write, mem_ready = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic ld_we;
  logic [NR-1:0] ld_sel;
  logic [31:0] ld_data, mm_base;
  logic busy, done, in_mode, nmi_blk, nmi_nest;

  mgmt_ctx_seq #(.BASE_RESET(B0)) dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] mem [0:127];
  logic [31:0] cur_base;
  int stall_mode = 0, wr_cnt = 0, rd_cnt = 0, bad_addr = 0, done_cnt = 0, busy_cnt = 0;
  logic [15:0] lfsr = 16'hACE1;
  int st_n = 0;
  int st_idx [0:63];
  logic [31:0] st_val [0:63];

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R10 watchdog: actual=still running expected=all sequences done");
      finish_run();
    end
  end

  function automatic int widx(input logic [31:0] rel);
    return int'((rel - 32'h7E00) >> 2);
  endfunction

  function automatic logic [31:0] exp_off(input int k);
    int s, f;
    logic [31:0] row;
    if (k < 14) return 32'h7FFC - 32'(4 * k);
    if (k == 14) return 32'h7F14;
    s = (k - 15) / 4;
    f = (k - 15) % 4;
    row = (s < 3) ? 32'h7F84 + 32'(12 * s) : 32'h7F2C + 32'(12 * (s - 3));
    if (f == 0) return 32'h7FA8 + 32'(4 * s);
    if (f == 1) return row + 8;
    if (f == 2) return row + 4;
    return row;
  endfunction

  function automatic bit attr_k(input int k);
    return (k >= 15) && ((k - 15) % 4 == 3);
  endfunction

  function automatic int ent_reg_e(input int j);
    if (j == 0) return 0;
    if (j == 1) return 3;
    if (j == 2) return 13;
    if (j == 3) return 14;
    return 15 + 4 * ((j - 4) / 3) + ((j - 4) % 3);
  endfunction

  function automatic logic [31:0] pat(input int p, input int k);
    return 32'h1357_9BDF + 32'(p) * 32'h0F0F_0101 + 32'(k) * 32'h0102_0408;
  endfunction

  function automatic logic [31:0] qpat(input int p, input int k);
    return 32'hA5C3_0000 ^ (32'(p) * 32'h0001_0203) ^ (32'(k) * 32'h0110_0011);
  endfunction

  // memory model and monitors, all at the falling edge
  always @(negedge clk) begin
    logic go;
    logic [31:0] rel;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    go = (stall_mode == 0) || (stall_mode == 1 && cyc[0]) || (stall_mode == 2 && lfsr[0]);
    if (mem_valid && go) begin
      rel = mem_addr - cur_base - 32'h8000;
      if (rel < 32'h7E00 || rel > 32'h7FFC || rel[1:0] != 2'b00) bad_addr++;
      else if (mem_write) begin mem[widx(rel)] = mem_wdata; wr_cnt++; end
      else begin mem_rdata = mem[widx(rel)]; rd_cnt++; end
      mem_ready = 1'b1;
    end else begin
      mem_ready = 1'b0;
    end
    if (ld_we) begin
      int hit;
      hit = -1;
      for (int b = 0; b < NR; b++) if (ld_sel[b]) hit = (hit == -1) ? b : 99;
      if (st_n < 64) begin st_idx[st_n] = hit; st_val[st_n] = ld_data; end
      st_n++;
    end
    if (done) done_cnt++;
    if (busy) busy_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    wr_cnt = 0; rd_cnt = 0; bad_addr = 0; done_cnt = 0; busy_cnt = 0; st_n = 0;
  endtask

  task automatic pulse(input int which);
    if (which == 0) enter_req = 1'b1;
    else if (which == 1) resume_req = 1'b1;
    else if (which == 2) nmi_block_set = 1'b1;
    else nmi_block_clr = 1'b1;
    @(negedge clk);
    enter_req = 0; resume_req = 0; nmi_block_set = 0; nmi_block_clr = 0;
  endtask

  // trigger, check busy, inject ignored triggers, wait for done
  task automatic run_op(input int which, input string tag);
    clear_counts();
    pulse(which);
    chk(busy == 1'b1, {tag, " R10 busy after trigger"}, 32'(busy), 1);
    @(negedge clk);
    enter_req = 1'b1; resume_req = 1'b1;
    @(negedge clk);
    enter_req = 0; resume_req = 0;
    while (done_cnt == 0) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, {tag, " R10 idle after done"}, 32'(busy), 0);
    @(negedge clk);
    chk(done_cnt == 1, {tag, " R10/R11 single done"}, 32'(done_cnt), 1);
  endtask

  task automatic idle_probe(input int which, input string tag);
    clear_counts();
    pulse(which);
    repeat (6) @(negedge clk);
    chk(busy_cnt == 0 && wr_cnt == 0 && rd_cnt == 0 && done_cnt == 0,
        {tag, " R11 trigger ignored"}, 32'(busy_cnt + wr_cnt + rd_cnt), 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    cur_base = B0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !ld_we, "R12 reset outputs", {29'b0, busy, done, ld_we}, 0);
    chk(!in_mode && !nmi_blk && !nmi_nest, "R12 reset flags", {29'b0, in_mode, nmi_blk, nmi_nest}, 0);
    chk(mm_base == B0, "R12 reset base", mm_base, B0);

    idle_probe(1, "pre");

    for (int p = 0; p < 8; p++) begin
      bit pre, reloc;
      logic [31:0] nb, revw, ebase, v;
      pre = p[1];
      reloc = !p[0];
      stall_mode = p % 3;
      if (pre) pulse(2);
      @(negedge clk);
      for (int k = 0; k < NR; k++) snap_regs[k*32 +: 32] = pat(p, k);

      // ---- entry ----
      run_op(0, "enter");
      chk(wr_cnt == NR + 2 && bad_addr == 0, "R2 write count", 32'(wr_cnt + 100 * bad_addr), NR + 2);
      for (int k = 0; k < NR; k++) begin
        v = attr_k(k) ? ((pat(p, k) >> 8) & 32'h0000_F0FF) : pat(p, k);
        chk(mem[widx(exp_off(k))] == v, $sformatf("R1 save slot k=%0d", k), mem[widx(exp_off(k))], v);
      end
      chk(mem[widx(32'h7EFC)] == 32'h0002_0000, "R2 revision word", mem[widx(32'h7EFC)], 32'h0002_0000);
      chk(mem[widx(32'h7EF8)] == cur_base, "R2 base word", mem[widx(32'h7EF8)], cur_base);
      chk(in_mode && nmi_blk && (nmi_nest == pre), "R3 entry flags",
          {29'b0, in_mode, nmi_blk, nmi_nest}, {29'b0, 1'b1, 1'b1, pre});
      chk(st_n == NE, "R4 entry strobe count", 32'(st_n), NE);
      for (int j = 0; j < NE && j < st_n; j++) begin
        int s, f;
        if (j == 0) v = pat(p, 0) & ~32'h8000_000D;
        else if (j == 1) v = 32'h8000;
        else if (j == 2) v = 32'h400;
        else if (j == 3) v = 0;
        else begin
          s = (j - 4) / 3; f = (j - 4) % 3;
          if (f == 2) v = 32'hFFFF_FFFF;
          else if (s != 1) v = 0;
          else v = (f == 0) ? ((cur_base >> 4) & 32'hFFFF) : cur_base;
        end
        chk(st_idx[j] == ent_reg_e(j) && st_val[j] == v,
            $sformatf("%s entry step %0d (sel %0d)", (j < 4) ? "R4" : "R5", j, st_idx[j]), st_val[j], v);
      end

      idle_probe(0, "in-mode");

      // ---- resume ----
      nb = 32'h0004_0000 + 32'(p) * 32'h0000_1230;
      revw = reloc ? (32'h0002_0000 | 32'(p)) : 32'h0001_0000;
      for (int k = 0; k < NR; k++) mem[widx(exp_off(k))] = qpat(p, k);
      mem[widx(32'h7EFC)] = revw;
      mem[widx(32'h7EF8)] = nb;
      run_op(1, "resume");
      chk(rd_cnt == NR + 1 + int'(reloc) && bad_addr == 0, "R7 read count",
          32'(rd_cnt + 100 * bad_addr), 32'(NR + 1 + int'(reloc)));
      chk(st_n == NR, "R6 restore strobe count", 32'(st_n), NR);
      for (int k = 0; k < NR && k < st_n; k++) begin
        v = attr_k(k) ? ((qpat(p, k) & 32'h0000_F0FF) << 8) : qpat(p, k);
        chk(st_idx[k] == k && st_val[k] == v, $sformatf("R6 restore k=%0d (sel %0d)", k, st_idx[k]), st_val[k], v);
      end
      ebase = reloc ? nb : cur_base;
      chk(mm_base == ebase, "R7 base after resume", mm_base, ebase);
      cur_base = mm_base;
      chk(!in_mode && !nmi_nest && (nmi_blk == pre), "R8 resume flags",
          {29'b0, in_mode, nmi_blk, nmi_nest}, {29'b0, 1'b0, pre, 1'b0});
      if (pre) begin
        pulse(3);
        @(negedge clk);
        chk(!nmi_blk, "R8 block clear after exit", 32'(nmi_blk), 0);
      end

      idle_probe(1, "out-of-mode");
    end

    // nested: block clear is ignored while entered inside a blocked NMI
    pulse(2);
    @(negedge clk);
    run_op(0, "nest");
    pulse(3);
    @(negedge clk);
    chk(nmi_blk && nmi_nest, "R8 clear ignored while nested", {30'b0, nmi_blk, nmi_nest}, 3);
    mem[widx(32'h7EFC)] = 32'h0;
    run_op(1, "nest-exit");
    chk(nmi_blk && !nmi_nest && !in_mode, "R8 nested exit keeps block",
        {29'b0, in_mode, nmi_blk, nmi_nest}, 32'b010);

    finish_run();
  end
endmodule